// File: doc/BRIEF.md
# Wallace tree multiplier

This block multiplies two unsigned N-bit integers and returns the full 2N-bit product. Every operand bit pair is ANDed to form a single-bit partial product. The weight of that bit is the sum of the two bit positions. Columns of equal-weight bits are then cut down by successive layers of full and half adders until no column holds more than two bits. One carry-propagate adder joins the two rows that remain.

The number of reduction layers grows with the logarithm of N. Each layer adds one full-adder delay. For the default N of 8, the column heights fall 8, 6, 4, 3, 2, so four layers are used.

Operands enter through a valid/ready handshake. By default a single output stage holds the product and its valid flag. That stage accepts a new operand pair when it is empty, or when its current result is being taken in the same cycle. If the downstream side stalls, the stage holds its result, and back-pressure reaches the upstream side at once through `in_ready`. The stage can be switched off with a parameter. The product and the handshake then pass straight through without a clock cycle.

Top module: `wt_mult`

## Requirements
- R1: `p` equals the unsigned product of the accepted `a` and `b`, as a 2N-bit value. Examples: 0xFF times 0xFF gives 0xFE01, and any operand of 0 gives 0.
- R2: When `in_valid` and `in_ready` are both high at a rising clock edge, `out_valid` is high and `p` carries that pair's product right after that edge.
- R3: `in_ready` is high exactly when the stage is empty (`out_valid` low) or `out_ready` is high. A new pair may replace a result in the same edge in which that result is taken.
- R4: While `out_valid` is high and `out_ready` is low, `p` and `out_valid` keep their values across clock edges, whatever `a`, `b` and `in_valid` do.
- R5: A clock edge with `rst` high clears `out_valid` to 0 and `p` to 0.
- R6: A clock edge with `out_valid` high, `out_ready` high and `in_valid` low leaves `out_valid` low.
- R7: A clock edge at which no pair is accepted leaves `p` unchanged, even if `a` and `b` change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output stage |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair on `a`/`b` is offered |
| in_ready | output | 1 | Block can take the offered pair this cycle |
| a | input | N | First unsigned operand |
| b | input | N | Second unsigned operand |
| out_valid | output | 1 | `p` holds a product not yet taken |
| out_ready | input | 1 | Downstream takes `p` this cycle |
| p | output | 2N | Unsigned product |

## Verification
With the output stage on, a product and its valid flag are due at the rising edge after the edge that accepted the pair. The bench drives operands at the falling edge and reads `p` and `out_valid` at the next falling edge, which is half a cycle after that due edge. `in_ready` depends directly on `out_valid` and `out_ready` without a register. It is therefore read at a falling edge, after `out_ready` has settled and before the rising edge that would use it. Checks for holding and for ignored inputs read the ports one full cycle after the stimulus that must have no effect.

// File: rtl/wt_pkg.sv
package wt_pkg;

  // Height of column c before any reduction: count of (i,j) pairs with i+j == c.
  function automatic int pp_height(int n, int c);
    if (c < n) return c + 1;
    if (c < 2 * n - 1) return 2 * n - 1 - c;
    return 0;
  endfunction

  // Bits a column keeps for itself after one layer: FA sums plus HA sum or passthrough.
  function automatic int own_bits(int h);
    return h / 3 + (((h % 3) != 0) ? 1 : 0);
  endfunction

  // Bits a column pushes into the next higher column: FA carries plus HA carry.
  function automatic int carry_bits(int h);
    return h / 3 + (((h % 3) == 2) ? 1 : 0);
  endfunction

  function automatic int col_h(int n, int lay, int c);
    if (c < 0 || c >= 2 * n) return 0;
    if (lay == 0) return pp_height(n, c);
    return own_bits(col_h(n, lay - 1, c)) + carry_bits(col_h(n, lay - 1, c - 1));
  endfunction

  function automatic int col_off(int n, int lay, int c);
    int s;
    s = 0;
    for (int k = 0; k < c; k++) s += col_h(n, lay, k);
    return s;
  endfunction

  function automatic int layer_bits(int n, int lay);
    return col_off(n, lay, 2 * n);
  endfunction

  function automatic int max_h(int n, int lay);
    int m;
    m = 0;
    for (int k = 0; k < 2 * n; k++) if (col_h(n, lay, k) > m) m = col_h(n, lay, k);
    return m;
  endfunction

  function automatic int num_layers(int n);
    int l;
    l = 0;
    while (max_h(n, l) > 2) l++;
    return l;
  endfunction

endpackage

// File: rtl/wt_tree.sv
module wt_tree
  import wt_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] row_x,
  output logic [2*N-1:0] row_y
);
  localparam int W  = 2 * N;
  localparam int NL = num_layers(N);

  // Layer l holds all bits of that level, packed column after column.
  for (genvar l = 0; l <= NL; l++) begin : gen_l
    localparam int TOT = layer_bits(N, l);
    logic [TOT-1:0] v;

    if (l == 0) begin : g_pp
      for (genvar c = 0; c < W - 1; c++) begin : g_c
        localparam int LO = (c > N - 1) ? c - N + 1 : 0;
        localparam int HI = (c < N - 1) ? c : N - 1;
        localparam int OF = col_off(N, 0, c);
        for (genvar i = LO; i <= HI; i++) begin : g_i
          assign v[OF+i-LO] = a[i] & b[c-i];
        end
      end
    end else begin : g_red
      for (genvar c = 0; c < W; c++) begin : g_c
        localparam int HT  = col_h(N, l - 1, c);
        localparam int NFA = HT / 3;
        localparam int REM = HT % 3;
        localparam int PI  = col_off(N, l - 1, c);
        localparam int PO  = col_off(N, l, c);
        // carries land after the own bits of the next column
        localparam int CO  = (c < W - 1) ?
                             col_off(N, l, c + 1) + own_bits(col_h(N, l - 1, c + 1)) : 0;

        for (genvar f = 0; f < NFA; f++) begin : g_fa
          logic x, y, z;
          assign x = gen_l[l-1].v[PI+3*f];
          assign y = gen_l[l-1].v[PI+3*f+1];
          assign z = gen_l[l-1].v[PI+3*f+2];
          assign v[PO+f] = x ^ y ^ z;
          if (c < W - 1) begin : g_cy
            assign v[CO+f] = (x & y) | (x & z) | (y & z);
          end
        end

        if (REM == 2) begin : g_ha
          logic x, y;
          assign x = gen_l[l-1].v[PI+3*NFA];
          assign y = gen_l[l-1].v[PI+3*NFA+1];
          assign v[PO+NFA] = x ^ y;
          if (c < W - 1) begin : g_cy
            assign v[CO+NFA] = x & y;
          end
        end else if (REM == 1) begin : g_pass
          assign v[PO+NFA] = gen_l[l-1].v[PI+3*NFA];
        end
      end
    end
  end

  // At most two bits per column remain: split into two rows.
  for (genvar c = 0; c < W; c++) begin : g_out
    localparam int H  = col_h(N, NL, c);
    localparam int OF = col_off(N, NL, c);
    if (H >= 1) begin : g_x
      assign row_x[c] = gen_l[NL].v[OF];
    end else begin : g_x0
      assign row_x[c] = 1'b0;
    end
    if (H >= 2) begin : g_y
      assign row_y[c] = gen_l[NL].v[OF+1];
    end else begin : g_y0
      assign row_y[c] = 1'b0;
    end
  end

endmodule

// File: rtl/wt_cpa.sv
module wt_cpa #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s
);
  // carry out of the top column is always zero for an unsigned product
  assign s = x + y;
endmodule

// File: rtl/wt_ostage.sv
module wt_ostage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] d,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] q
);
  logic         full;
  logic [W-1:0] hold;

  assign in_ready  = !full || out_ready;
  assign out_valid = full;
  assign q         = hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      hold <= '0;
    end else if (in_valid && in_ready) begin
      full <= 1'b1;
      hold <= d;
    end else if (out_ready) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/wt_mult.sv
module wt_mult #(
  parameter int N       = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [2*N-1:0] p
);
  localparam int W = 2 * N;

  logic [W-1:0] row_x, row_y, prod;

  wt_tree #(.N(N)) u_tree (
    .a     (a),
    .b     (b),
    .row_x (row_x),
    .row_y (row_y)
  );

  wt_cpa #(.W(W)) u_cpa (
    .x (row_x),
    .y (row_y),
    .s (prod)
  );

  if (OUT_REG) begin : g_reg
    wt_ostage #(.W(W)) u_stage (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .d         (prod),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .q         (p)
    );
  end else begin : g_comb
    assign p         = prod;
    assign out_valid = in_valid;
    assign in_ready  = out_ready;
  end
endmodule

// File: rtl/wt_mult_chk.sv
module wt_mult_chk #(
  parameter int N       = 8,
  parameter bit OUT_REG = 1'b1
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic           in_ready,
  input logic [N-1:0]   a,
  input logic [N-1:0]   b,
  input logic           out_valid,
  input logic           out_ready,
  input logic [2*N-1:0] p
);
  if (OUT_REG) begin : g_seq
    p_product_r1: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> (p == ({{N{1'b0}}, $past(a)} * {{N{1'b0}}, $past(b)})));

    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> out_valid);

    p_backpressure_r3: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |-> !in_ready);

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(p)));

    p_clear_r5: assert property (@(posedge clk)
      rst |=> (!out_valid && p == '0));

    p_drain_r6: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_ready && !in_valid) |=> !out_valid);

    p_keep_r7: assert property (@(posedge clk) disable iff (rst)
      !(in_valid && in_ready) |=> $stable(p));
  end else begin : g_comb
    p_product_r1: assert property (@(posedge clk)
      in_valid |-> (p == ({{N{1'b0}}, a} * {{N{1'b0}}, b})));
  end
endmodule

bind wt_mult wt_mult_chk #(.N(N), .OUT_REG(OUT_REG)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .a         (a),
  .b         (b),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .p         (p)
);

// File: tb/test_wt_mult.sv
module test_wt_mult;
  localparam int N = 8;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic         in_ready;
  logic [N-1:0] a, b;
  logic         out_valid;
  logic         out_ready;
  logic [W-1:0] p;
  logic [W-1:0] exp_p;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  wt_mult #(.N(N), .OUT_REG(1'b1)) i_wt_mult (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .a         (a),
    .b         (b),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .p         (p)
  );

  // {a, b, expected product}
  localparam logic [31:0] VEC [16] = '{
    {8'h00, 8'h00, 16'h0000}, {8'h01, 8'h01, 16'h0001},
    {8'hFF, 8'hFF, 16'hFE01}, {8'hFF, 8'h01, 16'h00FF},
    {8'hAA, 8'h55, 16'h3872}, {8'h55, 8'h55, 16'h1C39},
    {8'hAA, 8'hAA, 16'h70E4}, {8'h80, 8'h80, 16'h4000},
    {8'h0F, 8'hF0, 16'h0E10}, {8'h12, 8'h34, 16'h03A8},
    {8'hFF, 8'h00, 16'h0000}, {8'h7F, 8'h81, 16'h3FFF},
    {8'h10, 8'h10, 16'h0100}, {8'hC3, 8'h3C, 16'h2DB4},
    {8'hFE, 8'hFF, 16'hFD02}, {8'h02, 8'h80, 16'h0100}
  };

  task automatic chk(input bit ok, input string req,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; a = '0; b = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R5 reset valid", W'(out_valid), 16'h0);
    chk(p === 16'h0000, "R5 reset product", p, 16'h0000);
    rst = 1'b0;

    // vector table: R1 values, R2 one-cycle latency
    for (int k = 0; k < 16; k++) begin
      a = VEC[k][31:24]; b = VEC[k][23:16]; in_valid = 1'b1;
      @(negedge clk);
      chk(out_valid === 1'b1, "R2 valid after accept", W'(out_valid), 16'h1);
      chk(p === VEC[k][15:0], "R1 table", p, VEC[k][15:0]);
    end

    // every operand pair, one per cycle: R1
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        a = i[7:0]; b = j[7:0];
        exp_p = 16'(i * j);
        @(negedge clk);
        chk(out_valid === 1'b1 && p === exp_p, "R1 exhaustive", p, exp_p);
      end
    end

    // R6 drain, R7 product kept
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0, "R6 drained", W'(out_valid), 16'h0);
    chk(p === 16'hFE01, "R7 kept after drain", p, 16'hFE01);
    a = 8'h03; b = 8'h05;
    @(negedge clk);
    chk(out_valid === 1'b0 && p === 16'hFE01, "R7 idle operands ignored", p, 16'hFE01);

    // R3 / R4 back-pressure
    out_ready = 1'b0; a = 8'h0C; b = 8'h0D; in_valid = 1'b1;
    #1;
    chk(in_ready === 1'b1, "R3 empty ready", W'(in_ready), 16'h1);
    @(negedge clk);
    chk(out_valid === 1'b1 && p === 16'h009C, "R2 stalled load", p, 16'h009C);
    chk(in_ready === 1'b0, "R3 full blocked", W'(in_ready), 16'h0);
    a = 8'h21; b = 8'h02;
    @(negedge clk);
    chk(out_valid === 1'b1 && p === 16'h009C, "R4 hold under stall", p, 16'h009C);
    @(negedge clk);
    chk(p === 16'h009C, "R4 hold second cycle", p, 16'h009C);
    out_ready = 1'b1;
    #1;
    chk(in_ready === 1'b1, "R3 ready while draining", W'(in_ready), 16'h1);
    @(negedge clk);
    chk(out_valid === 1'b1 && p === 16'h0042, "R3 replace on drain", p, 16'h0042);
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0, "R6 drained after replace", W'(out_valid), 16'h0);

    // R5 reset of a loaded stage
    a = 8'hFF; b = 8'hFF; in_valid = 1'b1;
    @(negedge clk);
    chk(p === 16'hFE01, "R1 before reset", p, 16'hFE01);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0 && p === 16'h0000, "R5 reset clears loaded", p, 16'h0000);
    rst = 1'b0;
    @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule